// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block drains a ring of transmit descriptors that software fills in host memory. For each slot handed to hardware it reads the packet bytes from the buffer the descriptor points at, stages them in a small internal FIFO and streams them out on a byte-wide line interface. The first byte of a frame is marked with a start flag and the last byte with an end flag. When the frame is finished, the engine writes the descriptor back with ownership returned to software and a completion flag set.

The line may start before the whole frame has been fetched. The engine starts once a programmable number of bytes is buffered, or once the whole frame is buffered if the frame is shorter than that number. If the line is ready for the next byte while the FIFO is empty, the frame is aborted on the line and an underrun counter is incremented. A watchdog watches for a slot that is being processed but makes no progress. When it fires, it raises a sticky hang flag asking for the engine to be reset.

Memory reads have a variable latency. The engine keeps one read in flight, so a slow memory lowers the fetch rate below the line rate. This is the condition that produces underruns.

Top module: `tx_ring_engine`

## Requirements
- R1: A descriptor is `DW = AW+LW+2` bits: buffer address in bits [AW-1:0], byte length in bits [AW+LW-1:AW], done flag at bit AW+LW, owner flag at bit AW+LW+1. A slot is taken when owner=1 and done=0. Bytes are read from address base upward and sent in that order, with `tx_sop` on the first byte and `tx_eop` on the last.
- R2: No byte is sent (`tx_valid` stays 0) in a cycle where `line_rdy` is 0.
- R3: A frame starts on the line once the FIFO holds at least `start_thresh` bytes, or the whole frame, or a full FIFO, whichever comes first.
- R4: When the frame has started, `line_rdy` is 1, bytes remain and the FIFO is empty, the engine pulses `tx_abort` for one cycle with `tx_valid` low. It then increments `underrun_cnt` and drops the rest of the frame.
- R5: After the last byte of a frame, or after an abort, the engine writes the same slot back with owner=0, done=1 and address and length unchanged.
- R6: A descriptor with length 0 is written back as in R5 and no byte is sent.
- R7: Slots are served strictly in ring order, wrapping from slot SLOTS-1 to slot 0. A later slot that is owned is not served while the current slot is not owned.
- R8: If `hang_limit` (non-zero) consecutive busy cycles pass with no byte sent and no read returned, `hang` rises and stays high. While `hang` is high, no byte, read or write-back is issued. A `hang_limit` of 0 disables the watchdog.
- R9: While `rst_n` is low and after it is released, `hang`, `underrun_cnt`, `tx_valid`, `mem_rd` and `desc_we` are 0, and `desc_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears the ring state and the hang flag |
| start_thresh | input | LW | Bytes buffered before a frame starts on the line |
| hang_limit | input | HW | Stalled cycles before hang is raised; 0 disables |
| desc_idx | output | IW | Current ring slot |
| desc_rdata | input | DW | Descriptor at `desc_idx`, combinational |
| desc_we | output | 1 | Write-back strobe for slot `desc_idx` |
| desc_wdata | output | DW | Descriptor value written back |
| mem_rd | output | 1 | Memory read request, one byte |
| mem_addr | output | AW | Memory read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data |
| line_rdy | input | 1 | Line takes a byte this cycle |
| tx_valid | output | 1 | Byte on `tx_data` is sent |
| tx_data | output | 8 | Line byte |
| tx_sop | output | 1 | First byte of frame |
| tx_eop | output | 1 | Last byte of frame |
| tx_abort | output | 1 | Frame aborted by underrun |
| underrun_cnt | output | UW | Underrun count |
| hang | output | 1 | Ring stall detected, reset requested |

## Verification
The bench uses the default four slots and a 16-byte FIFO. With four slots the wrap to slot 0 is reached after a handful of frames. With a 16-byte FIFO, a 20-byte frame with a threshold of 16 starts on a full FIFO, while a threshold of 4 leaves room for an underrun. The bench's memory model switches read latency between 1 cycle, where the fetch keeps up with the line, and 3 cycles, where it falls behind. The hang limit is set to 100 for normal traffic, 20 to trigger the watchdog quickly, and 0 to show that it is disabled.

// File: rtl/tx_ring_engine.sv
module tx_ring_engine #(
  parameter int SLOTS = 4,
  parameter int AW = 16,
  parameter int LW = 12,
  parameter int FIFO_DEPTH = 16,
  parameter int HW = 16,
  parameter int UW = 8,
  localparam int IW = $clog2(SLOTS),
  localparam int FW = $clog2(FIFO_DEPTH),
  localparam int DW = AW + LW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] start_thresh,
  input  logic [HW-1:0] hang_limit,
  output logic [IW-1:0] desc_idx,
  input  logic [DW-1:0] desc_rdata,
  output logic          desc_we,
  output logic [DW-1:0] desc_wdata,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [7:0]    mem_rdata,
  input  logic          line_rdy,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_sop,
  output logic          tx_eop,
  output logic          tx_abort,
  output logic [UW-1:0] underrun_cnt,
  output logic          hang
);
  typedef enum logic [1:0] {S_IDLE, S_XFER, S_DRAIN, S_REL} st_t;
  st_t st;

  logic [IW-1:0] idx;
  logic [AW-1:0] base;
  logic [LW-1:0] len, fetched, sent;
  logic          pend, started;
  logic [7:0]    fifo [FIFO_DEPTH];
  logic [FW-1:0] wp, rp;
  logic [FW:0]   cnt;
  logic [HW-1:0] wd;

  wire          d_take = desc_rdata[DW-1] && !desc_rdata[DW-2];
  wire [LW-1:0] d_len  = desc_rdata[AW+LW-1:AW];
  wire          xfer   = !hang && st == S_XFER;
  wire          empty  = cnt == '0;
  wire          push   = xfer && pend && mem_rvalid;
  wire [LW-1:0] cnt_l  = LW'(cnt);
  wire          full   = cnt == (FW+1)'(FIFO_DEPTH);
  wire          go     = !empty && (cnt_l >= start_thresh || cnt_l == len || full);
  wire          room   = (cnt + (FW+1)'(pend)) < (FW+1)'(FIFO_DEPTH);
  wire          progress = tx_valid || (pend && mem_rvalid);

  assign desc_idx   = idx;
  assign desc_we    = !hang && st == S_REL;
  assign desc_wdata = {1'b0, 1'b1, len, base};
  assign mem_rd     = xfer && fetched < len && (!pend || mem_rvalid) && room;
  assign mem_addr   = base + AW'(fetched);
  assign tx_valid   = xfer && started && line_rdy && !empty;
  assign tx_abort   = xfer && started && line_rdy && empty;
  assign tx_data    = fifo[rp];
  assign tx_sop     = tx_valid && sent == '0;
  assign tx_eop     = tx_valid && sent == len - LW'(1);

  always_ff @(posedge clk)
    if (push) fifo[wp] <= mem_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      idx <= '0;
      base <= '0;
      len <= '0;
      fetched <= '0;
      sent <= '0;
      pend <= 1'b0;
      started <= 1'b0;
      wp <= '0;
      rp <= '0;
      cnt <= '0;
      wd <= '0;
      hang <= 1'b0;
      underrun_cnt <= '0;
    end else if (!hang) begin
      if (st != S_IDLE && !progress) begin
        if (hang_limit != '0 && wd == hang_limit - HW'(1)) hang <= 1'b1;
        else wd <= wd + HW'(1);
      end else begin
        wd <= '0;
      end

      if (push) wp <= wp + FW'(1);
      if (tx_valid) rp <= rp + FW'(1);
      cnt <= cnt + (FW+1)'(push) - (FW+1)'(tx_valid);
      if (mem_rd) fetched <= fetched + LW'(1);
      if (mem_rd) pend <= 1'b1;
      else if (mem_rvalid) pend <= 1'b0;

      case (st)
        S_IDLE: if (d_take) begin
          base <= desc_rdata[AW-1:0];
          len <= d_len;
          fetched <= '0;
          sent <= '0;
          started <= 1'b0;
          st <= (d_len == '0) ? S_REL : S_XFER;
        end
        S_XFER: begin
          if (!started && go) started <= 1'b1;
          if (tx_valid) begin
            sent <= sent + LW'(1);
            if (sent == len - LW'(1)) st <= S_REL;
          end
          if (tx_abort) begin
            underrun_cnt <= underrun_cnt + UW'(1);
            st <= S_DRAIN;
          end
        end
        S_DRAIN: if (!pend || mem_rvalid) st <= S_REL;
        S_REL: begin
          idx <= (idx == IW'(SLOTS - 1)) ? '0 : idx + IW'(1);
          wp <= '0;
          rp <= '0;
          cnt <= '0;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module tx_ring_engine_chk #(
  parameter int SLOTS = 4,
  parameter int IW = 2,
  parameter int UW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hang,
  input logic          tx_valid,
  input logic          tx_sop,
  input logic          tx_eop,
  input logic          tx_abort,
  input logic          line_rdy,
  input logic          mem_rd,
  input logic          desc_we,
  input logic [1:0]    rel_flags,
  input logic [IW-1:0] desc_idx,
  input logic [UW-1:0] underrun_cnt
);
  AST_FLAGS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n) (tx_sop || tx_eop) |-> tx_valid); // R1
  AST_NO_SEND_UNREADY: assert property (@(posedge clk) disable iff (!rst_n) !line_rdy |-> !tx_valid && !tx_abort); // R2
  AST_ABORT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n) tx_abort |-> !tx_valid); // R4
  AST_UNDERRUN_STEP: assert property (@(posedge clk) disable iff (!rst_n) tx_abort |=> underrun_cnt == $past(underrun_cnt) + 1'b1); // R4
  AST_RELEASE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) desc_we |-> rel_flags == 2'b01); // R5
  AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n) desc_we |=> desc_idx == (($past(desc_idx) == IW'(SLOTS - 1)) ? '0 : $past(desc_idx) + 1'b1)); // R7
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !desc_we |=> $stable(desc_idx)); // R7
  AST_HANG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) hang |=> hang); // R8
  AST_HANG_QUIET: assert property (@(posedge clk) disable iff (!rst_n) hang |-> !tx_valid && !mem_rd && !desc_we); // R8
  always_comb if (!rst_n) AST_RESET_IDLE: assert (!tx_valid && !mem_rd && !desc_we) else $error("reset idle"); // R9
endmodule

bind tx_ring_engine tx_ring_engine_chk #(.SLOTS(SLOTS), .IW(IW), .UW(UW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hang(hang), .tx_valid(tx_valid), .tx_sop(tx_sop),
  .tx_eop(tx_eop), .tx_abort(tx_abort), .line_rdy(line_rdy), .mem_rd(mem_rd),
  .desc_we(desc_we), .rel_flags(desc_wdata[DW-1:DW-2]), .desc_idx(desc_idx),
  .underrun_cnt(underrun_cnt)
);

// File: tb/tx_ring_engine_tb.sv
module tx_ring_engine_tb;
  localparam int SLOTS = 4, AW = 16, LW = 12, FD = 16, HW = 16, UW = 8;
  localparam int IW = 2, DW = AW + LW + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [LW-1:0] thr = 4;
  logic [HW-1:0] hl = 100;
  logic [IW-1:0] desc_idx;
  logic [DW-1:0] desc_rdata, desc_wdata;
  logic desc_we, mem_rd, mem_rvalid, tx_valid, tx_sop, tx_eop, tx_abort, hang;
  logic line_rdy = 1'b1;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_rdata, tx_data;
  logic [UW-1:0] underrun_cnt;

  tx_ring_engine #(.SLOTS(SLOTS), .AW(AW), .LW(LW), .FIFO_DEPTH(FD), .HW(HW), .UW(UW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_thresh(thr), .hang_limit(hl),
    .desc_idx(desc_idx), .desc_rdata(desc_rdata), .desc_we(desc_we), .desc_wdata(desc_wdata),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .line_rdy(line_rdy), .tx_valid(tx_valid), .tx_data(tx_data), .tx_sop(tx_sop),
    .tx_eop(tx_eop), .tx_abort(tx_abort), .underrun_cnt(underrun_cnt), .hang(hang));

  function automatic logic [7:0] pat(logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  // descriptor ring, all writes in one process
  logic [DW-1:0] ring [SLOTS];
  logic post_v = 1'b0, clr = 1'b0;
  int pslot;
  logic [DW-1:0] pdesc;
  assign desc_rdata = ring[desc_idx];
  always @(posedge clk) begin
    if (clr) for (int k = 0; k < SLOTS; k++) ring[k] <= '0;
    if (post_v) ring[pslot] <= pdesc;
    if (desc_we) ring[desc_idx] <= desc_wdata;
  end

  // memory with selectable latency
  int lat = 1;
  logic [3:0] vp;
  logic [AW-1:0] ap [4];
  always @(posedge clk) begin
    vp <= rst_n ? {vp[2:0], mem_rd} : 4'b0;
    ap[0] <= mem_addr;
    for (int k = 1; k < 4; k++) ap[k] <= ap[k-1];
  end
  assign mem_rvalid = vp[lat-1];
  assign mem_rdata  = pat(ap[lat-1]);

  int checks = 0, fails = 0;
  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard queues
  logic [7:0] exp_b[$];
  int exp_len[$];
  int exp_slot[$];
  logic [DW-1:0] exp_desc[$];
  int pos = 0, sent_bytes = 0, aborts = 0, rv = 0, rv_sop = -1, pace_bad = 0;

  always @(negedge clk) if (rst_n) begin
    if (tx_valid) begin
      sent_bytes++;
      if (!line_rdy) pace_bad++;
      if (tx_sop) rv_sop = rv;
      if (exp_b.size() == 0) chk(1'b0, "R1 unexpected byte", tx_data, 0);
      else begin
        chk(tx_data == exp_b[0] && tx_sop == (pos == 0) && tx_eop == (pos == exp_len[0] - 1),
            "R1 byte/sop/eop", {tx_sop, tx_eop, tx_data},
            {pos == 0, pos == exp_len[0] - 1, exp_b[0]});
        void'(exp_b.pop_front());
        pos++;
        if (pos == exp_len[0]) begin void'(exp_len.pop_front()); pos = 0; end
      end
    end
    if (tx_abort) begin
      aborts++;
      if (exp_len.size() != 0) begin
        for (int i = pos; i < exp_len[0]; i++) void'(exp_b.pop_front());
        void'(exp_len.pop_front());
      end
      pos = 0;
    end
    if (desc_we) begin
      rv = 0;
      if (exp_slot.size() == 0) chk(1'b0, "R5 unexpected write-back", desc_idx, 0);
      else begin
        chk(int'(desc_idx) == exp_slot[0] && desc_wdata == exp_desc[0], "R5/R7 write-back",
            {desc_idx, desc_wdata}, {exp_slot[0][IW-1:0], exp_desc[0]});
        void'(exp_slot.pop_front());
        void'(exp_desc.pop_front());
      end
    end
    if (mem_rvalid) rv++;
  end

  task automatic raw(int slot, logic [AW-1:0] addr, int len);
    @(negedge clk);
    pslot = slot;
    pdesc = {1'b1, 1'b0, LW'(len), addr};
    post_v = 1'b1;
    @(negedge clk);
    post_v = 1'b0;
  endtask

  task automatic expect_frame(int slot, logic [AW-1:0] addr, int len);
    for (int i = 0; i < len; i++) exp_b.push_back(pat(addr + AW'(i)));
    if (len != 0) exp_len.push_back(len);
    exp_slot.push_back(slot);
    exp_desc.push_back({1'b0, 1'b1, LW'(len), addr});
  endtask

  task automatic post(int slot, logic [AW-1:0] addr, int len);
    expect_frame(slot, addr, len);
    raw(slot, addr, len);
  endtask

  task automatic wait_done(string tag);
    int t = 0;
    while (exp_slot.size() != 0 && t < 3000) begin @(negedge clk); t++; end
    chk(exp_slot.size() == 0, tag, exp_slot.size(), 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    clr = 1'b1;
    exp_b.delete(); exp_len.delete(); exp_slot.delete(); exp_desc.delete();
    pos = 0;
    @(negedge clk);
    clr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    int b0, a0;
    for (int k = 0; k < SLOTS; k++) ring[k] = '0;
    do_reset();
    // R9 reset state
    chk(!tx_valid && !mem_rd && !desc_we && !hang, "R9 outputs idle", {tx_valid, mem_rd, desc_we, hang}, 0);
    chk(desc_idx == 0 && underrun_cnt == 0, "R9 index/counter", {desc_idx, underrun_cnt}, 0);

    // R1 frames of several lengths, fast memory
    post(0, 16'h0100, 5);
    post(1, 16'h0230, 1);
    post(2, 16'h0377, 17);
    wait_done("R1 frames complete");
    chk(underrun_cnt == 0, "R1 no underrun fast memory", underrun_cnt, 0);

    // R2 line pacing
    thr = 1;
    post(3, 16'h0450, 10);
    for (int i = 0; i < 40; i++) begin @(negedge clk); line_rdy = (i % 3) != 0; end
    line_rdy = 1'b1;
    wait_done("R2 paced frame complete");

    // R7 wrap to slot 0
    thr = 4;
    post(0, 16'h0500, 3);
    wait_done("R7 wrap frame complete");
    chk(desc_idx == 1, "R7 index after wrap", desc_idx, 1);

    // R7 a later slot is not served first
    b0 = sent_bytes;
    raw(2, 16'h0620, 4);
    repeat (40) @(negedge clk);
    chk(sent_bytes == b0 && desc_idx == 1, "R7 later slot waits", {sent_bytes - b0, desc_idx}, 1);
    post(1, 16'h0700, 2);
    expect_frame(2, 16'h0620, 4);
    wait_done("R7 in-order frames complete");

    // R6 zero length
    b0 = sent_bytes;
    post(3, 16'h0800, 0);
    wait_done("R6 zero-length released");
    chk(sent_bytes == b0, "R6 no byte sent", sent_bytes - b0, 0);

    // R3 threshold with slow memory
    lat = 3; thr = 16;
    post(0, 16'h0900, 20);
    wait_done("R3 threshold frame complete");
    chk(rv_sop >= 16, "R3 bytes buffered at start", rv_sop, 16);
    chk(underrun_cnt == 0, "R3 high threshold avoids underrun", underrun_cnt, 0);
    thr = 8;
    post(1, 16'h0A00, 3);
    wait_done("R3 short frame complete");
    chk(rv_sop == 3, "R3 short frame fully buffered", rv_sop, 3);

    // R4 underrun
    thr = 4;
    a0 = aborts;
    post(2, 16'h0B00, 20);
    wait_done("R4/R5 aborted frame released");
    chk(aborts - a0 == 1, "R4 one abort", aborts - a0, 1);
    chk(underrun_cnt == 1, "R4 counter", underrun_cnt, 1);
    lat = 1;
    post(3, 16'h0C00, 6);
    wait_done("R4 recovery frame complete");
    chk(underrun_cnt == 1, "R4 counter steady", underrun_cnt, 1);

    // R8 hang
    hl = 20; line_rdy = 1'b0;
    post(0, 16'h0D00, 8);
    repeat (60) @(negedge clk);
    chk(hang == 1'b1, "R8 hang raised", hang, 1);
    chk(!tx_valid && !mem_rd, "R8 frozen", {tx_valid, mem_rd}, 0);
    line_rdy = 1'b1;
    repeat (10) @(negedge clk);
    chk(hang == 1'b1 && !tx_valid, "R8 hang sticky", {hang, tx_valid}, 2);
    do_reset();
    chk(!hang && desc_idx == 0 && underrun_cnt == 0, "R9 reset clears", {hang, desc_idx, underrun_cnt}, 0);

    // R8 disabled watchdog
    hl = 0; line_rdy = 1'b0;
    post(0, 16'h0E00, 8);
    repeat (100) @(negedge clk);
    chk(hang == 1'b0, "R8 disabled watchdog", hang, 0);
    line_rdy = 1'b1;
    wait_done("R8 frame after stall");
    chk(exp_b.size() == 0, "R1 all bytes seen", exp_b.size(), 0);
    chk(pace_bad == 0, "R2 no byte while line not ready", pace_bad, 0);

    summary();
    $finish;
  end
endmodule